// File: doc/BRIEF.md
# Programmable Modulator Clock Divider

This block derives the sampling clock for a sigma-delta modulator. The source is either the block's own reference clock or an alternate PDM clock pin, chosen by a select input. An 8-bit divide factor sets the ratio. The code 0 silences the output. The code 1 hands the chosen source through unchanged. Any larger code n gives one output period per n source periods. A module enable holds the whole divider idle while it is low.

All logic runs on the reference clock. The alternate PDM clock passes through a two-flop synchronizer, and each rising edge of it becomes a one-cycle source tick. On the reference source, every cycle is a tick. The divider counts ticks. It drives two outputs: a registered output clock level, and a one-cycle strobe that marks the first tick of every output period. A change of factor or of source restarts the count from zero, so no runt pulse appears. A stable flag rises once the output has run two full periods at the current ratio.

Top module: `mod_clk_div`

## Requirements
- R1: After reset, div_clk_o, div_stb_o and stable_o are all 0.
- R2: With factor 0, div_clk_o and div_stb_o stay 0 and stable_o stays 0.
- R3: With factor 1, div_stb_o pulses on every source tick, and div_clk_o follows the selected raw source clock combinationally (clk_i when src_sel_i is 0, pdm_clk_i when it is 1).
- R4: With factor n of 2 or more, div_stb_o pulses once every n source ticks. div_clk_o is high for the first floor(n/2) ticks of each period and low for the rest. The strobe and the level both update in the cycle after the tick.
- R5: A clock edge that sees factor_i differ from the factor sampled at the previous edge restarts the divider. The count returns to zero, and the strobe, the level and stable_o are all 0 after that edge. The first strobe follows the first tick after the restart.
- R6: Holding the same factor value leaves the phase and stable_o untouched.
- R7: stable_o rises after the second complete output period following a restart (2n ticks, or 2 ticks for factor 1), and stays high until the next restart.
- R8: While en_i is 0, all three outputs are 0 and the divider is held in restart.
- R9: src_sel_i 0 selects the reference source, which gives a tick every clk_i cycle. src_sel_i 1 selects pdm_clk_i: a rising edge of pdm_clk_i before clk_i edge k becomes a tick seen at edge k+2. A change of src_sel_i restarts the divider as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; all logic runs on it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pdm_clk_i | input | 1 | Alternate PDM source clock, asynchronous |
| src_sel_i | input | 1 | 1 selects pdm_clk_i, 0 selects the reference |
| en_i | input | 1 | Module enable |
| factor_i | input | 8 | Divide factor (0 off, 1 bypass, n divide by n) |
| div_clk_o | output | 1 | Divided clock level (raw source in bypass) |
| div_stb_o | output | 1 | One-cycle strobe at the start of each output period |
| stable_o | output | 1 | Output has settled at the current ratio |

## Verification
The assertions assume that factor_i, src_sel_i and en_i are synchronous to clk_i and hold steady around its rising edge. They also assume that pdm_clk_i stays low or high for at least one clk_i period, so that the synchronizer sees every edge. The bench changes all control inputs only on the falling edge of clk_i. It toggles pdm_clk_i at half-periods of one to four reference cycles, drawn at random for each segment. Segments with random factors, sources and enables alternate with directed cases: the longest factor, bypass, and a restart in the middle of a period.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int unsigned FACTOR_W = 8;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned STABLE_PERIODS = 2;

  typedef enum logic {
    SRC_REF = 1'b0,
    SRC_PDM = 1'b1
  } src_e;
endpackage

// File: rtl/mcd_ctrl.sv
module mcd_ctrl #(
  parameter int unsigned FACTOR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                sel_i,
  input  logic [FACTOR_W-1:0] factor_i,
  output logic [FACTOR_W-1:0] fac_o,
  output logic                sel_o,
  output logic                byp_o,
  output logic                restart_o
);
  logic [FACTOR_W-1:0] fac_q;
  logic                sel_q;
  logic                byp_q;

  assign restart_o = !en_i || (factor_i != fac_q) || (sel_i != sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fac_q <= '0;
      sel_q <= 1'b0;
      byp_q <= 1'b0;
    end else begin
      fac_q <= factor_i;
      sel_q <= sel_i;
      byp_q <= en_i && (factor_i == FACTOR_W'(1));
    end
  end

  assign fac_o = fac_q;
  assign sel_o = sel_q;
  assign byp_o = byp_q;

  a_r5_restart_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && factor_i != $past(factor_i)) |-> restart_o);
endmodule

// File: rtl/mcd_src_tick.sv
module mcd_src_tick
  import mcd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pdm_clk_i,
  input  logic sel_i,
  output logic tick_o
);
  logic [SYNC_STAGES:0] sh_q;
  logic                 pdm_rise;
  src_e                 src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], pdm_clk_i};
  end

  assign pdm_rise = sh_q[SYNC_STAGES-1] && !sh_q[SYNC_STAGES];
  assign src      = src_e'(sel_i);

  always_comb begin
    unique case (src)
      SRC_PDM: tick_o = pdm_rise;
      default: tick_o = 1'b1;
    endcase
  end

  a_r9_ref_every_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> tick_o);
  a_r9_pdm_single_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && tick_o) |=> !(sel_i && tick_o && $stable(sel_i)));
endmodule

// File: rtl/mcd_counter.sv
module mcd_counter #(
  parameter int unsigned FACTOR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                restart_i,
  input  logic                tick_i,
  input  logic [FACTOR_W-1:0] fac_i,
  output logic                lvl_o,
  output logic                stb_o,
  output logic                wrap_o
);
  logic [FACTOR_W-1:0] cnt_q;
  logic                lvl_q;
  logic                stb_q;
  logic                run;
  logic                last;

  assign run    = tick_i && (fac_i != '0) && !restart_i;
  assign last   = (cnt_q == fac_i - FACTOR_W'(1));
  assign wrap_o = run && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
      stb_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (run) begin
        stb_q <= (cnt_q == '0);
        lvl_q <= (fac_i == FACTOR_W'(1)) ? 1'b1 : (cnt_q < (fac_i >> 1));
        cnt_q <= last ? '0 : cnt_q + FACTOR_W'(1);
      end else if (fac_i == '0) begin
        lvl_q <= 1'b0;
      end
    end
  end

  assign lvl_o = lvl_q;
  assign stb_o = stb_q;

  a_r4_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fac_i == '0) ? (cnt_q == '0) : (cnt_q < fac_i));
  a_r5_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0) && !stb_q);
endmodule

// File: rtl/mcd_stable.sv
module mcd_stable #(
  parameter int unsigned STABLE_PERIODS = 2,
  localparam int unsigned PW = $clog2(STABLE_PERIODS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic wrap_i,
  output logic stable_o
);
  logic [PW-1:0] per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  per_q <= '0;
    else if (restart_i)           per_q <= '0;
    else if (wrap_i && !stable_o) per_q <= per_q + PW'(1);
  end

  assign stable_o = (per_q == PW'(STABLE_PERIODS));

  a_r7_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_q <= PW'(STABLE_PERIODS));
endmodule

// File: rtl/mod_clk_div.sv
module mod_clk_div #(
  parameter int unsigned FACTOR_W       = mcd_pkg::FACTOR_W,
  parameter int unsigned SYNC_STAGES    = mcd_pkg::SYNC_STAGES,
  parameter int unsigned STABLE_PERIODS = mcd_pkg::STABLE_PERIODS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pdm_clk_i,
  input  logic                src_sel_i,
  input  logic                en_i,
  input  logic [FACTOR_W-1:0] factor_i,
  output logic                div_clk_o,
  output logic                div_stb_o,
  output logic                stable_o
);
  logic [FACTOR_W-1:0] fac_q;
  logic                sel_q;
  logic                byp_q;
  logic                restart;
  logic                tick;
  logic                lvl;
  logic                wrap;

  mcd_ctrl #(.FACTOR_W(FACTOR_W)) u_ctrl (
    .clk_i, .rst_ni, .en_i, .sel_i(src_sel_i), .factor_i,
    .fac_o(fac_q), .sel_o(sel_q), .byp_o(byp_q), .restart_o(restart)
  );

  mcd_src_tick #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk_i, .rst_ni, .pdm_clk_i, .sel_i(sel_q), .tick_o(tick)
  );

  mcd_counter #(.FACTOR_W(FACTOR_W)) u_cnt (
    .clk_i, .rst_ni, .restart_i(restart), .tick_i(tick), .fac_i(fac_q),
    .lvl_o(lvl), .stb_o(div_stb_o), .wrap_o(wrap)
  );

  mcd_stable #(.STABLE_PERIODS(STABLE_PERIODS)) u_stb (
    .clk_i, .rst_ni, .restart_i(restart), .wrap_i(wrap), .stable_o
  );

  // bypass hands the raw selected source through
  assign div_clk_o = (byp_q && en_i) ? (sel_q ? pdm_clk_i : clk_i) : lvl;

  a_r2_zero_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (factor_i == '0) |=> !div_stb_o && !stable_o && !lvl);
  a_r5_change_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (factor_i != $past(factor_i)) |=> !stable_o);
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stable_o && en_i && $stable(factor_i) && $stable(src_sel_i)) |=> stable_o);
  a_r8_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !div_stb_o && !stable_o && !div_clk_o);
  a_r3_bypass_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !src_sel_i && factor_i == FACTOR_W'(1) && $stable(factor_i)
     && $stable(src_sel_i) && $past(en_i)) |=> div_stb_o);
endmodule

// File: tb/mod_clk_div_tb.sv
module mod_clk_div_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pdm_clk_i = 1'b0;
  logic       src_sel_i = 1'b0;
  logic       en_i = 1'b0;
  logic [7:0] factor_i = 8'd0;
  logic       div_clk_o, div_stb_o, stable_o;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;
  string cur_req = "R4";
  int pdm_half = 2;
  int pdm_cnt = 0;

  always #4 clk_i = ~clk_i;

  mod_clk_div u_dut (
    .clk_i, .rst_ni, .pdm_clk_i, .src_sel_i, .en_i, .factor_i,
    .div_clk_o, .div_stb_o, .stable_o
  );

  // reference model built from the requirements
  int m_fac, m_cnt, m_per;
  bit m_sel, m_byp, m_lvl, m_stb, m_restart, m_tick;
  bit [2:0] m_sh;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_fac = 0; m_cnt = 0; m_per = 0; m_sel = 0; m_byp = 0;
      m_lvl = 0; m_stb = 0; m_sh = '0;
    end else begin
      m_restart = !en_i || (int'(factor_i) != m_fac) || (src_sel_i != m_sel);
      m_tick = m_sel ? (m_sh[1] && !m_sh[2]) : 1'b1;
      if (m_restart) begin
        m_cnt = 0; m_lvl = 0; m_stb = 0; m_per = 0;
      end else begin
        m_stb = 0;
        if (m_tick && m_fac != 0) begin
          m_stb = (m_cnt == 0);
          m_lvl = (m_fac == 1) ? 1'b1 : (m_cnt < m_fac / 2);
          if (m_cnt == m_fac - 1) begin
            m_cnt = 0;
            if (m_per < 2) m_per++;
          end else m_cnt++;
        end else if (m_fac == 0) m_lvl = 0;
      end
      m_byp = en_i && (factor_i == 8'd1);
      m_fac = int'(factor_i);
      m_sel = src_sel_i;
      m_sh = {m_sh[1:0], pdm_clk_i};
    end
  end

  function automatic string req_for();
    if (!en_i) return "R8";
    if (m_fac == 0) return "R2";
    if (m_fac == 1) return "R3";
    return cur_req;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    logic exp_clk;
    @(negedge clk_i);
    exp_clk = (m_byp && en_i) ? (m_sel ? pdm_clk_i : 1'b0) : m_lvl;
    chk(req_for(), div_stb_o, m_stb, "strobe");
    chk(req_for(), div_clk_o, exp_clk, "clock");
    chk({"R7/", req_for()}, stable_o, (m_per == 2), "stable");
    if (++pdm_cnt >= pdm_half) begin
      pdm_clk_i = ~pdm_clk_i;
      pdm_cnt = 0;
    end
  endtask

  task automatic run(input int cycles);
    for (int i = 0; i < cycles; i++) step();
  endtask

  function automatic logic [7:0] pick_factor();
    int r = $urandom_range(0, 19);
    if (r == 0) return 8'd0;
    if (r == 1) return 8'd1;
    if (r < 12) return 8'($urandom_range(2, 7));
    return 8'($urandom_range(8, 24));
  endfunction

  initial begin
    void'($urandom(32'h5eed_c10c));
    #1;
    // R1: reset state
    chk("R1", div_clk_o, 1'b0, "reset clock");
    chk("R1", div_stb_o, 1'b0, "reset strobe");
    chk("R1", stable_o, 1'b0, "reset stable");
    @(negedge clk_i);
    rst_ni = 1'b1;
    en_i = 1'b1;

    // R2: factor 0 keeps everything quiet
    factor_i = 8'd0;
    run(20);

    // R4: divide by 5 on reference, then R7 stable window
    cur_req = "R4";
    factor_i = 8'd5;
    run(40);

    // R3: bypass on reference, check high phase too
    factor_i = 8'd1;
    run(6);
    @(posedge clk_i); #1;
    chk("R3", div_clk_o, 1'b1, "bypass high phase");
    run(4);

    // R5: restart mid-period, stable must drop
    cur_req = "R5";
    factor_i = 8'd6;
    run(15);
    factor_i = 8'd4;
    run(1);
    chk("R5", stable_o, 1'b0, "stable after change");
    run(20);

    // R6: same value held, phase untouched
    cur_req = "R6";
    factor_i = 8'd4;
    run(20);

    // R8: disable mid-run
    en_i = 1'b0;
    run(10);
    en_i = 1'b1;
    run(10);

    // R9: PDM source with various rates
    cur_req = "R9";
    src_sel_i = 1'b1;
    factor_i = 8'd3;
    pdm_half = 2;
    run(60);
    factor_i = 8'd1;
    run(20);

    // largest factor on reference
    cur_req = "R4";
    src_sel_i = 1'b0;
    factor_i = 8'd255;
    run(600);

    // random segments
    for (int s = 0; s < 150; s++) begin
      en_i = ($urandom_range(0, 9) != 0);
      src_sel_i = ($urandom_range(0, 2) == 0);
      factor_i = pick_factor();
      pdm_half = $urandom_range(1, 4);
      cur_req = src_sel_i ? "R9" : "R4";
      run($urandom_range(10, 200));
    end

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule